// File: doc/BRIEF.md
# Peripheral Event Transfer Controller

This block serves interrupt requests without running an interrupt routine. It has a bank of channels. Each channel holds a source pointer, a destination pointer, a transfer counter and a small control word. When a channel's request line pulses, the block takes the memory bus and moves one byte or one word from the source address to the destination address. It then advances one of the two pointers and counts down the channel's counter. The CPU gives up only the bus beats the move needs.

When a request arrives for a channel whose counter has run down to zero, the block moves no data. It hands the request on as a standard interrupt on that channel's own interrupt line. A channel in continuous mode never touches its counter and never raises an interrupt. Software sets up the channels through a register port that can be written and read. A request pulse is held as pending until its channel is served. When several channels are pending, the lowest-numbered one is served first.

The controller is a four-state machine. `ST_IDLE` waits for a pending request. From there it takes the transition *launch* to `ST_FETCH` when the chosen channel may transfer, or the transition *exhaust* to `ST_RAISE` when its counter is zero and it is not continuous. `ST_FETCH` drives the read beat and moves on to `ST_STORE` when the beat is granted (*fetched*). `ST_STORE` drives the write beat and goes back to `ST_IDLE` on grant (*stored*), updating the channel's registers in that same cycle. `ST_RAISE` pulses the interrupt for one cycle and returns to `ST_IDLE` (*raised*).

Top module: `evtx_ctrl`

## Requirements
- R1: A one-cycle pulse on `trig_i[n]` is held as pending until channel n is served. Among pending channels, the lowest-numbered one is served first, and the others stay pending.
- R2: A transfer is exactly one read beat at the source pointer followed by one write beat at the destination pointer. In word mode the write carries the word that was read. In byte mode `bus_byte` is 1 and the write carries the low 8 bits of the read data, zero-extended.
- R3: While `bus_req` is 1 and `bus_gnt` is 0, `bus_req`, `bus_addr`, `bus_we`, `bus_byte` and `bus_wdata` hold their values.
- R4: After a transfer, exactly one pointer advances: the destination pointer when control bit 1 is 1, otherwise the source pointer. It advances by 2 in word mode (control bit 0 is 1) and by 1 in byte mode.
- R5: Each transfer lowers the counter by one unless the channel is continuous (control bit 2 is 1). In continuous mode the counter is left unchanged.
- R6: A request on a non-continuous channel whose counter is zero makes no bus beat and leaves both pointers unchanged. It raises `irq_o[n]` for exactly one cycle and consumes the request.
- R7: A continuous channel never raises `irq_o`, even when its counter reads zero.
- R8: When `cfg_wr` is 1, the field chosen by `cfg_sel` of channel `cfg_ch` is written with `cfg_wdata`. The field codes are 0 source pointer, 1 destination pointer, 2 counter and 3 control word. `cfg_rdata` returns the same field, zero-extended.
- R9: After reset, every channel register reads zero, and `bus_req` and `irq_o` are 0.
- R10: At most one bit of `irq_o` is 1 at a time, and `irq_o` is never 1 while `bus_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_i | input | NCH | Per-channel service request pulses |
| cfg_wr | input | 1 | Register write strobe |
| cfg_ch | input | CHW | Channel selected for register access |
| cfg_sel | input | 2 | Field select: 0 source, 1 destination, 2 counter, 3 control |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Selected field, zero-extended |
| bus_req | output | 1 | Bus beat request |
| bus_gnt | input | 1 | Bus grant; the beat completes in the cycle it is high |
| bus_we | output | 1 | 1 for the write beat, 0 for the read beat |
| bus_byte | output | 1 | 1 for a byte-size beat |
| bus_addr | output | AW | Beat address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, sampled when the read beat is granted |
| irq_o | output | NCH | One-cycle standard interrupt pulse per channel |

## Verification
Some rules hold on every cycle, and the assertions check these continuously. They cover the bus handshake: a stalled request holds still, and every granted read is followed straight away by a write. That write carries exactly the data read, trimmed to a byte in byte mode. They also cover the interrupt line: it is one-hot, it lasts a single cycle, and it never overlaps a bus beat. Other behaviour depends on channel state held across requests, and only the bench scenarios can show it. This includes which pointer advances and by how much, and whether the counter falls or stays put. It also includes the switch to an interrupt once the counter is exhausted, the silence of continuous channels, and the order in which pending channels are served.

// File: rtl/evtx_pkg.sv
package evtx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE,
        ST_RAISE
    } evtx_state_e;

    // control word layout: bit2 continuous, bit1 advance destination, bit0 word size
    typedef struct packed {
        logic cont;
        logic inc_dst;
        logic word;
    } evtx_ctl_t;

    localparam int CTL_W = $bits(evtx_ctl_t);

    localparam logic [1:0] FLD_SRC = 2'd0;
    localparam logic [1:0] FLD_DST = 2'd1;
    localparam logic [1:0] FLD_CNT = 2'd2;
    localparam logic [1:0] FLD_CTL = 2'd3;

endpackage

// File: rtl/evtx_pend.sv
module evtx_pend #(
    parameter int NCH = 8,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] trig_i,
    input  logic           clr_en,
    input  logic [CHW-1:0] clr_ch,
    output logic           any_o,
    output logic [CHW-1:0] idx_o
);

    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (clr_en) clr_mask[clr_ch] = 1'b1;
    end

    // a new pulse wins over the clear of the same channel
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | trig_i;
    end

    // lowest-numbered pending channel wins
    always_comb begin
        idx_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend_q[i]) idx_o = CHW'(i);
        end
    end

    assign any_o = |pend_q;

endmodule

// File: rtl/evtx_chan_regs.sv
module evtx_chan_regs
    import evtx_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 24,
    parameter int CW  = 8,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [1:0]     cfg_sel,
    input  logic [AW-1:0]  cfg_wdata,
    output logic [AW-1:0]  cfg_rdata,
    input  logic           upd_en,
    input  logic [CHW-1:0] look_ch,
    output logic [AW-1:0]  look_src,
    output logic [AW-1:0]  look_dst,
    output logic [CW-1:0]  look_cnt,
    output evtx_ctl_t      look_ctl
);

    logic [AW-1:0] src_q [NCH];
    logic [AW-1:0] dst_q [NCH];
    logic [CW-1:0] cnt_q [NCH];
    evtx_ctl_t     ctl_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic          hit_upd;
        logic          hit_cfg;
        logic [AW-1:0] step;

        assign hit_upd = upd_en && (look_ch == CHW'(g));
        assign hit_cfg = cfg_wr && (cfg_ch == CHW'(g));
        assign step    = ctl_q[g].word ? AW'(2) : AW'(1);

        // an engine update takes precedence over a software write in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_q[g] <= '0;
                dst_q[g] <= '0;
                cnt_q[g] <= '0;
                ctl_q[g] <= '0;
            end else if (hit_upd) begin
                if (ctl_q[g].inc_dst) dst_q[g] <= dst_q[g] + step;
                else                  src_q[g] <= src_q[g] + step;
                if (!ctl_q[g].cont)   cnt_q[g] <= cnt_q[g] - CW'(1);
            end else if (hit_cfg) begin
                unique case (cfg_sel)
                    FLD_SRC: src_q[g] <= cfg_wdata;
                    FLD_DST: dst_q[g] <= cfg_wdata;
                    FLD_CNT: cnt_q[g] <= cfg_wdata[CW-1:0];
                    FLD_CTL: ctl_q[g] <= evtx_ctl_t'(cfg_wdata[CTL_W-1:0]);
                    default: ;
                endcase
            end
        end
    end

    assign look_src = src_q[look_ch];
    assign look_dst = dst_q[look_ch];
    assign look_cnt = cnt_q[look_ch];
    assign look_ctl = ctl_q[look_ch];

    always_comb begin
        unique case (cfg_sel)
            FLD_SRC: cfg_rdata = src_q[cfg_ch];
            FLD_DST: cfg_rdata = dst_q[cfg_ch];
            FLD_CNT: cfg_rdata = AW'(cnt_q[cfg_ch]);
            FLD_CTL: cfg_rdata = AW'(ctl_q[cfg_ch]);
            default: cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/evtx_fsm.sv
module evtx_fsm
    import evtx_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 24,
    parameter int DW  = 16,
    parameter int CW  = 8,
    parameter int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           any_pend,
    input  logic [CHW-1:0] pick_idx,
    output logic [CHW-1:0] look_ch,
    input  logic [AW-1:0]  look_src,
    input  logic [AW-1:0]  look_dst,
    input  logic [CW-1:0]  look_cnt,
    input  evtx_ctl_t      look_ctl,
    output logic           upd_en,
    output logic           clr_en,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic           bus_we,
    output logic           bus_byte,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq_o
);

    localparam int BYTE_W = 8;

    evtx_state_e    state_q, state_d;
    logic [CHW-1:0] cur_q;
    logic [DW-1:0]  data_q;
    logic           exhausted;

    assign exhausted = (look_cnt == '0) && !look_ctl.cont;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // channel and data holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            data_q <= '0;
        end else begin
            if (state_q == ST_IDLE && any_pend) cur_q <= pick_idx;
            if (state_q == ST_FETCH && bus_gnt) data_q <= bus_rdata;
        end
    end

    // transitions: launch, exhaust, fetched, stored, raised
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_pend) state_d = exhausted ? ST_RAISE : ST_FETCH;
            end
            ST_FETCH: if (bus_gnt) state_d = ST_STORE;
            ST_STORE: if (bus_gnt) state_d = ST_IDLE;
            ST_RAISE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        look_ch   = (state_q == ST_IDLE) ? pick_idx : cur_q;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_byte  = !look_ctl.word;
        bus_addr  = look_src;
        bus_wdata = look_ctl.word ? data_q : DW'(data_q[BYTE_W-1:0]);
        irq_o     = '0;
        upd_en    = 1'b0;
        clr_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FETCH: begin
                bus_req  = 1'b1;
                bus_addr = look_src;
            end
            ST_STORE: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = look_dst;
                upd_en   = bus_gnt;
                clr_en   = bus_gnt;
            end
            ST_RAISE: begin
                irq_o[cur_q] = 1'b1;
                clr_en       = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/evtx_ctrl.sv
module evtx_ctrl
    import evtx_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 24,
    parameter int DW  = 16,
    parameter int CW  = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] trig_i,
    input  logic           cfg_wr,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [1:0]     cfg_sel,
    input  logic [AW-1:0]  cfg_wdata,
    output logic [AW-1:0]  cfg_rdata,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic           bus_we,
    output logic           bus_byte,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq_o
);

    logic           any_pend;
    logic [CHW-1:0] pick_idx;
    logic [CHW-1:0] look_ch;
    logic [AW-1:0]  look_src;
    logic [AW-1:0]  look_dst;
    logic [CW-1:0]  look_cnt;
    evtx_ctl_t      look_ctl;
    logic           upd_en;
    logic           clr_en;

    evtx_pend #(.NCH(NCH), .CHW(CHW)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .clr_en (clr_en),
        .clr_ch (look_ch),
        .any_o  (any_pend),
        .idx_o  (pick_idx)
    );

    evtx_chan_regs #(.NCH(NCH), .AW(AW), .CW(CW), .CHW(CHW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_ch    (cfg_ch),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .upd_en    (upd_en),
        .look_ch   (look_ch),
        .look_src  (look_src),
        .look_dst  (look_dst),
        .look_cnt  (look_cnt),
        .look_ctl  (look_ctl)
    );

    evtx_fsm #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW), .CHW(CHW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_pend  (any_pend),
        .pick_idx  (pick_idx),
        .look_ch   (look_ch),
        .look_src  (look_src),
        .look_dst  (look_dst),
        .look_cnt  (look_cnt),
        .look_ctl  (look_ctl),
        .upd_en    (upd_en),
        .clr_en    (clr_en),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .bus_we    (bus_we),
        .bus_byte  (bus_byte),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/evtx_chk.sv
module evtx_chk #(
    parameter int NCH = 8,
    parameter int AW  = 24,
    parameter int DW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_req,
    input logic           bus_gnt,
    input logic           bus_we,
    input logic           bus_byte,
    input logic [AW-1:0]  bus_addr,
    input logic [DW-1:0]  bus_wdata,
    input logic [DW-1:0]  bus_rdata,
    input logic [NCH-1:0] irq_o
);

    logic [DW-1:0] seen_data;
    logic          seen_byte;
    logic          seen_rd;
    logic [DW-1:0] want_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_data <= '0;
            seen_byte <= 1'b0;
            seen_rd   <= 1'b0;
        end else if (bus_req && bus_gnt && !bus_we) begin
            seen_data <= bus_rdata;
            seen_byte <= bus_byte;
            seen_rd   <= 1'b1;
        end else if (bus_req && bus_gnt && bus_we) begin
            seen_rd   <= 1'b0;
        end
    end

    assign want_wdata = seen_byte ? DW'(seen_data[7:0]) : seen_data;

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_byte) && $stable(bus_wdata)));

    assert_write_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && !bus_we) |=> (bus_req && bus_we));

    assert_write_has_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> seen_rd);

    assert_write_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && seen_rd) |-> (bus_wdata == want_wdata && bus_byte == seen_byte));

    assert_irq_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));

    assert_irq_no_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> !bus_req);

    assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |=> !(|irq_o));

endmodule

bind evtx_ctrl evtx_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_we    (bus_we),
    .bus_byte  (bus_byte),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
);

// File: tb/sim_evtx_ctrl.sv
`timescale 1ns/1ps
module sim_evtx_ctrl;

    localparam int NCH = 8;
    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int CW  = 8;
    localparam int CHW = $clog2(NCH);

    typedef struct packed {
        logic [2:0]  ch;
        logic [2:0]  ctl;
        logic [15:0] src;
        logic [15:0] dst;
        logic [7:0]  cnt;
        logic [15:0] data;
        logic [15:0] xsrc;
        logic [15:0] xdst;
        logic [7:0]  xcnt;
    } vec_t;

    // ctl = {continuous, advance destination, word}
    localparam vec_t VECS [4] = '{
        '{3'd0, 3'b000, 16'h0010, 16'h0080, 8'd3, 16'h00A5, 16'h0011, 16'h0080, 8'd2},
        '{3'd1, 3'b011, 16'h0020, 16'h0090, 8'd1, 16'h1234, 16'h0020, 16'h0092, 8'd0},
        '{3'd3, 3'b101, 16'h0030, 16'h00A0, 8'd0, 16'hBEEF, 16'h0032, 16'h00A0, 8'd0},
        '{3'd7, 3'b010, 16'h0041, 16'h00B3, 8'd5, 16'h995C, 16'h0041, 16'h00B4, 8'd4}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] trig_i = '0;
    logic           cfg_wr = 1'b0;
    logic [CHW-1:0] cfg_ch = '0;
    logic [1:0]     cfg_sel = '0;
    logic [AW-1:0]  cfg_wdata = '0;
    logic [AW-1:0]  cfg_rdata;
    logic           bus_req, bus_we, bus_byte;
    logic           bus_gnt = 1'b1;
    logic [AW-1:0]  bus_addr;
    logic [DW-1:0]  bus_wdata, bus_rdata;
    logic [NCH-1:0] irq_o;

    logic [7:0]     mem [256];
    logic           poke_en = 1'b0;
    logic [7:0]     poke_addr = '0;
    logic [15:0]    poke_data = '0;

    int n_chk = 0, n_fail = 0;
    int irq_cnt [NCH];
    int wr_n = 0;
    logic [AW-1:0] wr_log [64];
    bit done = 0;

    always #5 clk = ~clk;

    evtx_ctrl #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) u0 (
        .clk, .rst_n, .trig_i, .cfg_wr, .cfg_ch, .cfg_sel, .cfg_wdata, .cfg_rdata,
        .bus_req, .bus_gnt, .bus_we, .bus_byte, .bus_addr, .bus_wdata, .bus_rdata, .irq_o
    );

    // little-endian byte memory environment
    assign bus_rdata = {mem[8'(bus_addr[7:0] + 8'd1)], mem[bus_addr[7:0]]};

    always @(posedge clk) begin
        if (poke_en) begin
            mem[poke_addr]          <= poke_data[7:0];
            mem[8'(poke_addr + 1)]  <= poke_data[15:8];
        end else if (bus_req && bus_gnt && bus_we) begin
            mem[bus_addr[7:0]] <= bus_wdata[7:0];
            if (!bus_byte) mem[8'(bus_addr[7:0] + 8'd1)] <= bus_wdata[15:8];
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int i = 0; i < NCH; i++) irq_cnt[i] = 0;
    end

    always @(negedge clk) begin
        for (int i = 0; i < NCH; i++) if (irq_o[i]) irq_cnt[i]++;
        if (bus_req && bus_gnt && bus_we) begin
            if (wr_n < 64) wr_log[wr_n] = bus_addr;
            wr_n++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_put(input int ch, input logic [1:0] sel, input int val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_ch = CHW'(ch); cfg_sel = sel; cfg_wdata = AW'(val);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_get(input int ch, input logic [1:0] sel, output int val);
        @(negedge clk);
        cfg_ch = CHW'(ch); cfg_sel = sel;
        #1 val = int'(cfg_rdata);
    endtask

    task automatic poke(input int addr, input int data);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = 8'(addr); poke_data = 16'(data);
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic fire(input logic [NCH-1:0] m);
        @(negedge clk);
        trig_i = m;
        @(negedge clk);
        trig_i = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : main
        int v, wr0, irq0;
        logic [7:0] exp_hi;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(bus_req == 1'b0, "R9 bus_req after reset", bus_req, 0);
        check(irq_o == '0, "R9 irq after reset", irq_o, 0);
        cfg_get(0, 2'd0, v); check(v == 0, "R9 ch0 src reset", v, 0);
        cfg_get(7, 2'd3, v); check(v == 0, "R9 ch7 ctl reset", v, 0);
        rst_n = 1'b1;
        idle(2);

        // vector table: R2 R4 R5 R7 R8
        foreach (VECS[k]) begin
            cfg_put(VECS[k].ch, 2'd0, VECS[k].src);
            cfg_put(VECS[k].ch, 2'd1, VECS[k].dst);
            cfg_put(VECS[k].ch, 2'd2, VECS[k].cnt);
            cfg_put(VECS[k].ch, 2'd3, VECS[k].ctl);
            poke(VECS[k].src, VECS[k].data);
            cfg_get(VECS[k].ch, 2'd3, v);
            check(v == VECS[k].ctl, "R8 control readback", v, VECS[k].ctl);
            fire(NCH'(1) << VECS[k].ch);
            idle(8);
            exp_hi = VECS[k].ctl[0] ? VECS[k].data[15:8] : 8'h00;
            check(mem[VECS[k].dst[7:0]] == VECS[k].data[7:0], "R2 low byte moved",
                  mem[VECS[k].dst[7:0]], VECS[k].data[7:0]);
            check(mem[8'(VECS[k].dst[7:0] + 1)] == exp_hi, "R2 upper byte per size",
                  mem[8'(VECS[k].dst[7:0] + 1)], exp_hi);
            cfg_get(VECS[k].ch, 2'd0, v);
            check(v == VECS[k].xsrc, "R4 source pointer", v, VECS[k].xsrc);
            cfg_get(VECS[k].ch, 2'd1, v);
            check(v == VECS[k].xdst, "R4 destination pointer", v, VECS[k].xdst);
            cfg_get(VECS[k].ch, 2'd2, v);
            check(v == VECS[k].xcnt, "R5 counter", v, VECS[k].xcnt);
            check(irq_cnt[VECS[k].ch] == 0, "R7 no interrupt on transfer",
                  irq_cnt[VECS[k].ch], 0);
        end

        // R6: ch1 counter is now zero, next request becomes an interrupt
        wr0 = wr_n;
        fire(8'h02);
        idle(6);
        check(irq_cnt[1] == 1, "R6 one interrupt pulse", irq_cnt[1], 1);
        check(wr_n == wr0, "R6 no bus beat", wr_n, wr0);
        cfg_get(1, 2'd1, v); check(v == 16'h0092, "R6 destination unchanged", v, 16'h0092);
        cfg_get(1, 2'd0, v); check(v == 16'h0020, "R6 source unchanged", v, 16'h0020);
        fire(8'h00); idle(4);
        check(irq_cnt[1] == 1, "R6 request consumed", irq_cnt[1], 1);

        // R1: simultaneous requests, lower channel first, other stays pending
        cfg_put(4, 2'd0, 16'h0050); cfg_put(4, 2'd1, 16'h00C0);
        cfg_put(4, 2'd2, 2);        cfg_put(4, 2'd3, 3'b000);
        cfg_put(6, 2'd0, 16'h0058); cfg_put(6, 2'd1, 16'h00C8);
        cfg_put(6, 2'd2, 2);        cfg_put(6, 2'd3, 3'b000);
        poke(16'h0050, 16'h0011);   poke(16'h0058, 16'h0022);
        wr0 = wr_n;
        fire(8'h50);
        idle(12);
        check(wr_n == wr0 + 2, "R1 both channels served", wr_n, wr0 + 2);
        check(wr_log[wr0] == 16'h00C0, "R1 lowest channel first", wr_log[wr0], 16'h00C0);
        check(wr_log[wr0 + 1] == 16'h00C8, "R1 pending channel later", wr_log[wr0 + 1], 16'h00C8);
        check(mem[8'hC8] == 8'h22, "R1 second transfer data", mem[8'hC8], 8'h22);

        // R3: stalled grant holds the read beat
        poke(16'h0011, 16'h0077);
        wr0 = wr_n;
        @(negedge clk) bus_gnt = 1'b0;
        fire(8'h01);
        idle(6);
        check(bus_req == 1'b1, "R3 request held while stalled", bus_req, 1);
        check(bus_addr == 16'h0011 && !bus_we, "R3 read address held", bus_addr, 16'h0011);
        check(wr_n == wr0, "R3 no write while stalled", wr_n, wr0);
        @(negedge clk) bus_gnt = 1'b1;
        idle(6);
        check(mem[8'h80] == 8'h77, "R3 transfer after grant", mem[8'h80], 8'h77);
        cfg_get(0, 2'd0, v); check(v == 16'h0012, "R4 byte step on source", v, 16'h0012);
        cfg_get(0, 2'd2, v); check(v == 1, "R5 counter after stall", v, 1);

        // R7: continuous channel with zero counter keeps moving data
        irq0 = irq_cnt[3];
        fire(8'h08); idle(6);
        fire(8'h08); idle(6);
        check(irq_cnt[3] == irq0, "R7 continuous never interrupts", irq_cnt[3], irq0);
        cfg_get(3, 2'd2, v); check(v == 0, "R5 continuous counter unchanged", v, 0);
        cfg_get(3, 2'd0, v); check(v == 16'h0036, "R4 word step on source", v, 16'h0036);

        // R8: counter field width and readback
        cfg_put(5, 2'd2, 16'h01AB);
        cfg_get(5, 2'd2, v); check(v == 16'h00AB, "R8 counter field readback", v, 16'h00AB);
        cfg_put(5, 2'd3, 16'hFFFD);
        cfg_get(5, 2'd3, v); check(v == 5, "R8 control field readback", v, 5);
        check(irq_o == '0 && !bus_req, "R10 quiet when idle", irq_o, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule